// File: doc/BRIEF.md
# DDR2 Bank Command Timing Checker

This block sits passively on the command side of a DDR2 memory bus. On every clock edge it samples the strobes and the bank and address inputs, and it recognises four commands: row activate, column read, column write and precharge. Each of the four banks has its own tracker. The tracker knows whether the bank's row is open, counts the cycles since that bank was last activated and last closed, and models a pending auto-precharge. A shared counter measures the gap since the last activate to any bank, and it remembers which bank that activate went to.

Every command is tested against the bank-state rules and the minimum spacing rules. The spacing limits come from configuration inputs given in clock cycles. The first broken rule sets a violation flag and stores a 3-bit reason code. Both are held until reset, so a long run can be checked at the end without any event being lost. The open or closed state of every bank is also brought out, so the checker's view of the memory can be compared with the controller's view.

Top module: `ddr2_cmd_checker`

## Requirements
- R1: A command is taken only when cs_n is low. With ras_n/cas_n/we_n at L/H/H it is an activate, at H/L/H a read, at H/L/L a write, and at L/H/L a precharge. A cycle with cs_n high, or with any other strobe pattern, changes no state and flags nothing.
- R2: After reset all banks read closed, viol is 0 and viol_code is 0. All counters start saturated, so the first activate to any bank is never a spacing violation.
- R3: An activate sets bank_open[ba]. A precharge with addr[10] low clears bank_open[ba]. A precharge with addr[10] high closes every open bank, and each bank it closes is checked against tRAS. A precharge to a bank that is already closed has no effect.
- R4: A read or write to a closed bank gives reason code 1.
- R5: An activate to a bank that is already open gives reason code 2.
- R6: A read or write to an open bank gives reason code 3 when the cycles elapsed since that bank's activate plus cfg_al is less than cfg_trcd. An activate at edge k followed by a read at edge k+d has elapsed d.
- R7: A precharge that closes a bank whose elapsed cycles since its activate are less than cfg_tras gives reason code 4.
- R8: An activate gives reason code 5 when the cycles since that bank was last closed are less than cfg_trp.
- R9: An activate gives reason code 6 when the cycles since that bank's previous activate are less than cfg_trc.
- R10: An activate to a bank other than the most recently activated one gives reason code 7 when the cycles since that activate are less than cfg_trrd.
- R11: A read or write with addr[10] high, issued to an open bank at edge k, closes that bank at edge k+cfg_bl. That close counts as a precharge for the tRP rule. A later read or write with addr[10] high restarts the wait, and an explicit precharge or activate cancels it.
- R12: viol_code keeps the reason code of the first violating command until reset, and viol stays high. When one command breaks several rules, the lowest code is recorded.
- R13: Every elapsed-cycle counter stops at 2^CNT_W-1, so a long idle gap never wraps around into a false violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, low to take a command |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable strobe |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address; bit 10 selects auto-precharge or all-bank precharge |
| cfg_al | input | 3 | Additive latency, 0 to 6 |
| cfg_bl | input | 4 | Cycles from an auto-precharge read/write to the bank closing, at least 1 |
| cfg_trcd | input | 6 | Activate to read/write minimum, cycles |
| cfg_tras | input | 6 | Activate to precharge minimum, cycles |
| cfg_trp | input | 6 | Close to activate minimum, cycles |
| cfg_trc | input | 6 | Activate to activate, same bank, cycles |
| cfg_trrd | input | 6 | Activate to activate, different banks, cycles |
| bank_open | output | 4 | Open state of each bank |
| viol | output | 1 | Sticky violation flag |
| viol_code | output | 3 | Reason code of the first violation |

## Verification
The embedded properties assume several things about the inputs. Reset is held for at least one edge. The configuration inputs change only while reset is low, and cfg_bl is never zero. They also assume that the command seen at an edge is the only command for that cycle. The stimulus writes configuration only inside its reset task, always picks a burst length of 1 to 8, and presents exactly one encoded pattern per cycle. The random phase prefers commands that break no rule, so each episode runs deep into open-bank and auto-precharge sequences before its first violation locks the code.

// File: rtl/ddr2_chk_pkg.sv
// Shared types for the DDR2 command checker.
// Assumes: reason codes fit in 3 bits and code 0 means "no violation".
package ddr2_chk_pkg;

    typedef enum logic [2:0] {
        V_NONE     = 3'd0,
        V_RW_IDLE  = 3'd1,
        V_ACT_BUSY = 3'd2,
        V_RCD      = 3'd3,
        V_RAS      = 3'd4,
        V_RP       = 3'd5,
        V_RC       = 3'd6,
        V_RRD      = 3'd7
    } viol_e;

    localparam int NUM_RULES = 7;

    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic a10;
    } cmd_t;

endpackage

// File: rtl/ddr2_cmd_decode.sv
// Command decoder: turns the strobe pins into one-hot command flags.
// Assumes: active-low strobes; any pattern other than the four
// recognised ones, or cs_n high, is treated as no command.
module ddr2_cmd_decode
    import ddr2_chk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_t cmd
);

    // Map the strobe pattern onto command flags.
    always_comb begin
        cmd     = '0;
        cmd.a10 = a10;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd.act = 1'b1;
                3'b101:  cmd.rd  = 1'b1;
                3'b100:  cmd.wr  = 1'b1;
                3'b010:  cmd.pre = 1'b1;
                default: cmd     = '{default: 1'b0, a10: a10};
            endcase
        end
    end

endmodule

// File: rtl/ddr2_bank_tracker.sv
// One bank's state: open flag, elapsed cycles since the last activate
// and since the last close, and a pending auto-precharge countdown.
// Produces this bank's rule-violation flags for the current command.
// Assumes: cfg_* stable outside reset, cfg_bl >= 1, CNT_W >= 3.
module ddr2_bank_tracker
    import ddr2_chk_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int BL_W    = 4,
    parameter int AL_W    = 3,
    parameter int BA_W    = 2,
    parameter int BANK_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_t             cmd,
    input  logic [BA_W-1:0]  ba,
    input  logic [AL_W-1:0]  cfg_al,
    input  logic [BL_W-1:0]  cfg_bl,
    input  logic [CNT_W-1:0] cfg_trcd,
    input  logic [CNT_W-1:0] cfg_tras,
    input  logic [CNT_W-1:0] cfg_trp,
    input  logic [CNT_W-1:0] cfg_trc,
    output logic             open_o,
    output logic [5:0]       err_o     // bit i = reason code i+1
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [BA_W-1:0]  MY_BANK = BANK_ID[BA_W-1:0];

    logic             open_q;
    logic [CNT_W-1:0] since_act_q;
    logic [CNT_W-1:0] since_pre_q;
    logic             ap_pend_q;
    logic [BL_W-1:0]  ap_cnt_q;

    logic             sel, act_hit, rw_hit, pre_hit;
    logic             pre_close, ap_load, ap_fire, close_evt;
    logic [CNT_W:0]   rcd_sum;

    // Command hits aimed at this bank.
    always_comb begin
        sel     = (ba == MY_BANK);
        act_hit = cmd.act & sel;
        rw_hit  = (cmd.rd | cmd.wr) & sel;
        pre_hit = cmd.pre & (sel | cmd.a10);
    end

    // Derived events: explicit close, auto-precharge arm and fire.
    always_comb begin
        pre_close = pre_hit & open_q;
        ap_load   = rw_hit & open_q & cmd.a10;
        ap_fire   = ap_pend_q & (ap_cnt_q <= BL_W'(1))
                  & ~act_hit & ~pre_close & ~ap_load;
        close_evt = pre_close | ap_fire;
        rcd_sum   = {1'b0, since_act_q} + (CNT_W+1)'(cfg_al);
    end

    // Rule checks against the state before this edge.
    always_comb begin
        err_o    = '0;
        err_o[0] = rw_hit & ~open_q;
        err_o[1] = act_hit & open_q;
        err_o[2] = rw_hit & open_q & (rcd_sum < {1'b0, cfg_trcd});
        err_o[3] = pre_close & (since_act_q < cfg_tras);
        err_o[4] = act_hit & (since_pre_q < cfg_trp);
        err_o[5] = act_hit & (since_act_q < cfg_trc);
    end

    // Open flag follows activate, precharge and auto-precharge close.
    always_ff @(posedge clk) begin
        if (!rst_n)         open_q <= 1'b0;
        else if (act_hit)   open_q <= 1'b1;
        else if (close_evt) open_q <= 1'b0;
    end

    // Cycles since the last activate, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                   since_act_q <= CNT_MAX;
        else if (act_hit)             since_act_q <= CNT_W'(1);
        else if (since_act_q != CNT_MAX) since_act_q <= since_act_q + 1'b1;
    end

    // Cycles since the bank last closed, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                   since_pre_q <= CNT_MAX;
        else if (close_evt)           since_pre_q <= CNT_W'(1);
        else if (since_pre_q != CNT_MAX) since_pre_q <= since_pre_q + 1'b1;
    end

    // Pending auto-precharge countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ap_pend_q <= 1'b0;
            ap_cnt_q  <= '0;
        end else if (act_hit || pre_close || ap_fire) begin
            ap_pend_q <= 1'b0;
        end else if (ap_load) begin
            ap_pend_q <= 1'b1;
            ap_cnt_q  <= cfg_bl;
        end else if (ap_pend_q) begin
            ap_cnt_q  <= ap_cnt_q - 1'b1;
        end
    end

    assign open_o = open_q;

    p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_hit |=> open_q);
    p_pre_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.pre && (ba == MY_BANK || cmd.a10)) |=> !open_q);
    p_ap_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_pend_q && ap_cnt_q <= BL_W'(1) && !cmd.act && !cmd.rd && !cmd.wr && !cmd.pre)
        |=> !open_q);
    p_no_wrap_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (since_act_q == CNT_MAX && !act_hit) |=> since_act_q == CNT_MAX);
    p_pre_no_wrap_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (since_pre_q == CNT_MAX && !close_evt) |=> since_pre_q == CNT_MAX);

endmodule

// File: rtl/ddr2_viol_log.sv
// Sticky violation record: latches the lowest-numbered rule raised by
// the first violating command and holds it until reset.
// Assumes: hit bit i stands for reason code i+1.
module ddr2_viol_log
    import ddr2_chk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RULES-1:0] hits,
    output logic                 viol,
    output logic [2:0]           viol_code
);

    viol_e first;
    logic  viol_q;
    viol_e code_q;

    // Fixed priority: the lowest code wins.
    always_comb begin
        first = V_NONE;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hits[i]) first = viol_e'(i + 1);
        end
    end

    // Latch only the first violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
            code_q <= V_NONE;
        end else if (!viol_q && (hits != '0)) begin
            viol_q <= 1'b1;
            code_q <= first;
        end
    end

    assign viol      = viol_q;
    assign viol_code = code_q;

    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |=> (viol_q && $stable(code_q)));
    p_code_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |-> (code_q != V_NONE));
    p_first_hit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_q && hits != '0) |=> viol_q);

endmodule

// File: rtl/ddr2_cmd_checker.sv
// DDR2 command timing checker top: decodes the bus, runs one tracker
// per bank, checks activate-to-activate spacing across banks and logs
// the first violation.
// Assumes: one command per cycle; configuration changes only in reset.
module ddr2_cmd_checker
    import ddr2_chk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int CNT_W     = 6,
    parameter int BL_W      = 4,
    parameter int AL_W      = 3,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [AL_W-1:0]      cfg_al,
    input  logic [BL_W-1:0]      cfg_bl,
    input  logic [CNT_W-1:0]     cfg_trcd,
    input  logic [CNT_W-1:0]     cfg_tras,
    input  logic [CNT_W-1:0]     cfg_trp,
    input  logic [CNT_W-1:0]     cfg_trc,
    input  logic [CNT_W-1:0]     cfg_trrd,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 viol,
    output logic [2:0]           viol_code
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cmd_t             cmd;
    logic [5:0]       bank_err [NUM_BANKS];
    logic [5:0]       err_any;
    logic [CNT_W-1:0] since_any_q;
    logic [BA_W-1:0]  last_ba_q;
    logic             rrd_err;
    logic [NUM_RULES-1:0] hits;
    logic             unused_addr;

    assign unused_addr = ^{addr[ADDR_W-1:11], addr[9:0]};

    ddr2_cmd_decode i_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (addr[10]),
        .cmd   (cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ddr2_bank_tracker #(
            .CNT_W   (CNT_W),
            .BL_W    (BL_W),
            .AL_W    (AL_W),
            .BA_W    (BA_W),
            .BANK_ID (b)
        ) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd),
            .ba       (ba),
            .cfg_al   (cfg_al),
            .cfg_bl   (cfg_bl),
            .cfg_trcd (cfg_trcd),
            .cfg_tras (cfg_tras),
            .cfg_trp  (cfg_trp),
            .cfg_trc  (cfg_trc),
            .open_o   (bank_open[b]),
            .err_o    (bank_err[b])
        );
    end

    // Merge per-bank rule flags.
    always_comb begin
        err_any = '0;
        for (int b = 0; b < NUM_BANKS; b++) err_any |= bank_err[b];
    end

    // Cycles since the last activate to any bank, and which bank it was.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_any_q <= CNT_MAX;
            last_ba_q   <= '0;
        end else if (cmd.act) begin
            since_any_q <= CNT_W'(1);
            last_ba_q   <= ba;
        end else if (since_any_q != CNT_MAX) begin
            since_any_q <= since_any_q + 1'b1;
        end
    end

    // Cross-bank activate spacing.
    always_comb rrd_err = cmd.act & (ba != last_ba_q) & (since_any_q < cfg_trrd);

    // Assemble the rule vector in code order.
    always_comb hits = {rrd_err, err_any};

    ddr2_viol_log i_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .hits      (hits),
        .viol      (viol),
        .viol_code (viol_code)
    );

    p_one_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd.act, cmd.rd, cmd.wr, cmd.pre}));
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !viol) |=> !viol);
    p_any_no_wrap_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (since_any_q == CNT_MAX && !cmd.act) |=> since_any_q == CNT_MAX);

endmodule

// File: tb/test_ddr2_cmd_checker.sv
module test_ddr2_cmd_checker;

    localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_CSNOP = 5;
    localparam int MAXC = 63;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [12:0] addr = '0;
    logic [2:0] cfg_al = '0;
    logic [3:0] cfg_bl = 4'd4;
    logic [5:0] cfg_trcd = 6'd4, cfg_tras = 6'd8, cfg_trp = 6'd3, cfg_trc = 6'd11, cfg_trrd = 6'd2;
    logic [3:0] bank_open;
    logic viol;
    logic [2:0] viol_code;

    int n_checks = 0, n_errors = 0;
    bit done = 0;

    int m_open[4], m_sa[4], m_sp[4], m_ap[4], m_apc[4];
    int m_any, m_last, m_viol, m_code;

    always #5 clk = ~clk;

    ddr2_cmd_checker i_ddr2_cmd_checker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .cfg_al(cfg_al), .cfg_bl(cfg_bl),
        .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
        .cfg_trc(cfg_trc), .cfg_trrd(cfg_trrd), .bank_open(bank_open),
        .viol(viol), .viol_code(viol_code)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v >= MAXC) ? MAXC : v + 1;
    endfunction

    // Expected reason code of a command against the model state.
    function automatic int exp_code(input int c, input int b, input int a10);
        if (c == C_RD || c == C_WR) begin
            if (!m_open[b]) return 1;
            if (m_sa[b] + int'(cfg_al) < int'(cfg_trcd)) return 3;
            return 0;
        end
        if (c == C_ACT) begin
            if (m_open[b]) return 2;
            if (m_sp[b] < int'(cfg_trp)) return 5;
            if (m_sa[b] < int'(cfg_trc)) return 6;
            if (b != m_last && m_any < int'(cfg_trrd)) return 7;
            return 0;
        end
        if (c == C_PRE) begin
            for (int i = 0; i < 4; i++)
                if ((a10 != 0 || i == b) && m_open[i] != 0 && m_sa[i] < int'(cfg_tras)) return 4;
        end
        return 0;
    endfunction

    function automatic string code_tag(input int code);
        case (code)
            1: return "R4";  2: return "R5";  3: return "R6";  4: return "R7";
            5: return "R8";  6: return "R9";  7: return "R10";
            default: return "R1";
        endcase
    endfunction

    function automatic int open_vec();
        int v = 0;
        for (int i = 0; i < 4; i++) if (m_open[i] != 0) v |= (1 << i);
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 0; m_sa[i] = MAXC; m_sp[i] = MAXC; m_ap[i] = 0; m_apc[i] = 0;
        end
        m_any = MAXC; m_last = 0; m_viol = 0; m_code = 0;
    endtask

    task automatic model_update(input int c, input int b, input int a10);
        int code = exp_code(c, b, a10);
        for (int i = 0; i < 4; i++) begin
            bit act_hit = (c == C_ACT) && (i == b);
            bit pre_cl  = (c == C_PRE) && (a10 != 0 || i == b) && m_open[i] != 0;
            bit ap_ld   = (c == C_RD || c == C_WR) && (i == b) && m_open[i] != 0 && a10 != 0;
            if (act_hit) begin
                m_open[i] = 1; m_sa[i] = 1; m_ap[i] = 0; m_sp[i] = sat(m_sp[i]);
            end else if (pre_cl) begin
                m_open[i] = 0; m_sp[i] = 1; m_ap[i] = 0; m_sa[i] = sat(m_sa[i]);
            end else if (ap_ld) begin
                m_ap[i] = 1; m_apc[i] = int'(cfg_bl);
                m_sa[i] = sat(m_sa[i]); m_sp[i] = sat(m_sp[i]);
            end else if (m_ap[i] != 0 && m_apc[i] <= 1) begin
                m_open[i] = 0; m_sp[i] = 1; m_ap[i] = 0; m_sa[i] = sat(m_sa[i]);
            end else begin
                if (m_ap[i] != 0) m_apc[i]--;
                m_sa[i] = sat(m_sa[i]); m_sp[i] = sat(m_sp[i]);
            end
        end
        if (c == C_ACT) begin m_any = 1; m_last = b; end
        else m_any = sat(m_any);
        if (m_viol == 0 && code != 0) begin m_viol = 1; m_code = code; end
    endtask

    // One bus cycle: drive at the falling edge, check after the rising edge.
    task automatic step(input int c, input int b, input int a10, input string tag);
        string t;
        int code;
        @(negedge clk);
        ba = 2'(b);
        addr = 13'($urandom);
        addr[10] = a10[0];
        cs_n = 1'b0;
        case (c)
            C_ACT:   {ras_n, cas_n, we_n} = 3'b011;
            C_RD:    {ras_n, cas_n, we_n} = 3'b101;
            C_WR:    {ras_n, cas_n, we_n} = 3'b100;
            C_PRE:   {ras_n, cas_n, we_n} = 3'b010;
            C_CSNOP: {ras_n, cas_n, we_n} = 3'b111;
            default: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'($urandom); end
        endcase
        code = exp_code(c, b, a10);
        t = (tag != "") ? tag : (m_viol != 0 ? "R12" : code_tag(code));
        model_update(c, b, a10);
        @(posedge clk);
        #2;
        chk(viol == m_viol[0], t, "viol", int'(viol), m_viol);
        chk(int'(viol_code) == m_code, t, "viol_code", int'(viol_code), m_code);
        chk(int'(bank_open) == open_vec(), (tag != "") ? tag : "R3", "bank_open", int'(bank_open), open_vec());
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(C_NOP, 0, 0, tag);
    endtask

    task automatic do_reset(input int al, input int bl, input int trc);
        @(negedge clk);
        rst_n = 1'b0;
        cs_n = 1'b1;
        cfg_al = 3'(al); cfg_bl = 4'(bl); cfg_trc = 6'(trc);
        cfg_trcd = 6'd4; cfg_tras = 6'd8; cfg_trp = 6'd3; cfg_trrd = 6'd2;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        chk(viol == 1'b0, "R2", "reset viol", int'(viol), 0);
        chk(viol_code == 3'd0, "R2", "reset code", int'(viol_code), 0);
        chk(bank_open == 4'd0, "R2", "reset banks", int'(bank_open), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: ignored patterns
        do_reset(0, 4, 11);
        idle(5, "R1");
        step(C_CSNOP, 1, 0, "R1");
        step(C_ACT, 0, 0, "R3");
        step(C_CSNOP, 0, 1, "R1");
        idle(3, "R1");
        step(C_RD, 0, 0, "R6");
        // R6 with additive latency: 1+2 < 4 flags, 1+3 passes
        do_reset(2, 4, 11);
        step(C_ACT, 1, 0, "R3");
        step(C_RD, 1, 0, "R6");
        do_reset(3, 4, 11);
        step(C_ACT, 1, 0, "R3");
        step(C_WR, 1, 0, "R6");
        // R5 and lowest-code priority (also breaks tRC)
        do_reset(0, 4, 11);
        step(C_ACT, 0, 0, "R5");
        step(C_ACT, 0, 0, "R5");
        step(C_RD, 2, 0, "R12");
        // R4
        do_reset(0, 4, 11);
        step(C_RD, 2, 0, "R4");
        // R7 tRAS: elapsed 7 flags
        do_reset(0, 4, 11);
        step(C_ACT, 0, 0, "R7");
        idle(6, "R7");
        step(C_PRE, 0, 0, "R7");
        do_reset(0, 4, 11);
        step(C_ACT, 0, 0, "R7");
        idle(7, "R7");
        step(C_PRE, 0, 0, "R7");
        // R8 tRP
        do_reset(0, 4, 11);
        step(C_ACT, 0, 0, "R8");
        idle(10, "R8");
        step(C_PRE, 0, 0, "R8");
        idle(1, "R8");
        step(C_ACT, 0, 0, "R8");
        // R9 tRC
        do_reset(0, 4, 14);
        step(C_ACT, 0, 0, "R9");
        idle(7, "R9");
        step(C_PRE, 0, 0, "R9");
        idle(2, "R9");
        step(C_ACT, 0, 0, "R9");
        // R10 tRRD
        do_reset(0, 4, 11);
        step(C_ACT, 0, 0, "R10");
        step(C_ACT, 1, 0, "R10");
        do_reset(0, 4, 11);
        step(C_ACT, 0, 0, "R10");
        idle(1, "R10");
        step(C_ACT, 1, 0, "R10");
        // R11 auto-precharge then tRP from the close
        do_reset(0, 4, 11);
        step(C_ACT, 3, 0, "R11");
        idle(3, "R11");
        step(C_RD, 3, 1, "R11");
        idle(5, "R11");
        step(C_ACT, 3, 0, "R11");
        do_reset(0, 2, 11);
        step(C_ACT, 3, 0, "R11");
        idle(3, "R11");
        step(C_WR, 3, 1, "R11");
        idle(2, "R11");
        step(C_ACT, 3, 0, "R11");
        // R3 precharge all
        do_reset(0, 4, 11);
        step(C_ACT, 0, 0, "R3");
        idle(1, "R3");
        step(C_ACT, 1, 0, "R3");
        idle(10, "R3");
        step(C_PRE, 2, 1, "R3");
        step(C_PRE, 2, 0, "R3");
        // R13 long idle gaps
        do_reset(0, 4, 11);
        step(C_ACT, 0, 0, "R13");
        idle(100, "R13");
        step(C_PRE, 0, 0, "R13");
        idle(3, "R13");
        step(C_ACT, 0, 0, "R13");
        idle(80, "R13");
        step(C_ACT, 1, 0, "R13");
        // Random episodes, biased towards legal commands
        for (int ep = 0; ep < 40; ep++) begin
            do_reset($urandom_range(0, 6), $urandom_range(1, 8), $urandom_range(8, 14));
            for (int s = 0; s < 60; s++) begin
                int c = C_NOP, b = 0, a = 0;
                for (int k = 0; k < 4; k++) begin
                    int r = $urandom_range(0, 99);
                    c = (r < 40) ? C_NOP : (r < 60) ? C_ACT : (r < 75) ? C_RD :
                        (r < 85) ? C_WR : (r < 97) ? C_PRE : C_CSNOP;
                    b = $urandom_range(0, 3);
                    a = ($urandom_range(0, 3) == 0) ? 1 : 0;
                    if (exp_code(c, b, a) == 0) break;
                end
                step(c, b, a, "");
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule